// File: doc/BRIEF.md
# TLB Maintenance Command Decoder

This block sits between the system-register write path and two translation lookaside buffers, one for instruction fetch and one for data access. It watches each register write. When the write index names a TLB maintenance operation, the block turns that write into a flush command for the instruction TLB, the data TLB, or both. A command is one of four kinds: flush everything, flush one address space ID, flush one page for one ASID, or flush one page across every ASID. The page address and the ASID are cut out of the written data word.

Several indices are aliases. A unified form and an inner-shareable form both reach both TLBs, and each TLB also has its own set of single-target variants. A second group of indices covers the context ID, the two memory-remap registers and the domain access register. Writing any of these pulses a single invalidate of cached translation state, so that both TLBs re-read those registers. The block only signals the invalidate. It does not swallow the write.

Each command leaves the block registered, as a one-cycle pulse, on the cycle after the write is accepted. The block holds off the writer, through `wr_ready`, while any TLB that the current index targets is not ready.

Top module: `tlb_maint_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it, `itlb_cmd_valid`, `dtlb_cmd_valid` and `tlb_state_inv` are low.
- R2: Indices 0 to 7 reach both TLBs with identical op, address and ASID. Index pairs {0,1} flush all, {2,3} flush by page and ASID, {4,5} flush by ASID, and {6,7} flush by page for all ASIDs.
- R3: For page-based ops, the command address equals write data bits 31:12 with bits 11:0 forced to zero.
- R4: For ASID-based ops, the command ASID equals write data bits 7:0. A flush-all op carries an address of 0 and an ASID of 0.
- R5: A flush-by-page-all-ASIDs op (op code 3) carries an ASID of 0. A by-ASID op (code 1) carries an address of 0.
- R6: Indices 8 (all), 9 (page+ASID) and 10 (ASID) issue a command to the instruction TLB only.
- R7: Indices 11 (all), 12 (page+ASID) and 13 (ASID) issue a command to the data TLB only.
- R8: Indices 16 to 19 (context ID, the two remap registers, domain access) raise `tlb_state_inv` for one cycle, issue no flush command and are never back-pressured.
- R9: Every other index produces no output and is accepted at once.
- R10: `wr_ready` is low exactly when the index targets a TLB whose ready input is low. A write that is not accepted produces no output.
- R11: Outputs appear on the cycle after acceptance and last one cycle. Op codes are 0 = all, 1 = by ASID, 2 = by page and ASID, 3 = by page for all ASIDs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write present |
| wr_index | input | IDX_W | Register index being written |
| wr_data | input | DATA_W | Write data word |
| wr_ready | output | 1 | Write accepted this cycle when high with wr_valid |
| itlb_ready | input | 1 | Instruction TLB can take a command |
| itlb_cmd_valid | output | 1 | One-cycle instruction TLB command strobe |
| itlb_cmd_op | output | 2 | Instruction TLB command op code |
| itlb_cmd_va | output | DATA_W | Page-aligned address for the instruction TLB |
| itlb_cmd_asid | output | ASID_W | ASID for the instruction TLB |
| dtlb_ready | input | 1 | Data TLB can take a command |
| dtlb_cmd_valid | output | 1 | One-cycle data TLB command strobe |
| dtlb_cmd_op | output | 2 | Data TLB command op code |
| dtlb_cmd_va | output | DATA_W | Page-aligned address for the data TLB |
| dtlb_cmd_asid | output | ASID_W | ASID for the data TLB |
| tlb_state_inv | output | 1 | One-cycle invalidate of cached translation state |

## Verification
The bench builds the block with its defaults: a 5-bit index, 32-bit data, a 12-bit page shift and an 8-bit ASID. With these values the random index covers the whole space of 32 indices, including the unmapped holes at 14, 15 and 20 to 31. The data word is wide enough that bits 11:8 and 31:12 carry independent values, which shows that the page and ASID fields are cut out correctly. Each TLB's ready input is toggled at random, so partial back-pressure also occurs: one TLB ready and the other not, for both-target and single-target indices alike.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    typedef enum logic [1:0] {
        OP_ALL     = 2'd0,
        OP_ASID    = 2'd1,
        OP_VA_ASID = 2'd2,
        OP_VA_ANY  = 2'd3
    } tlbm_op_e;

    // Number of command targets: 0 = instruction TLB, 1 = data TLB
    localparam int NTGT = 2;

    typedef struct packed {
        logic     to_i;
        logic     to_d;
        logic     inv;
        tlbm_op_e op;
    } tlbm_dec_t;

    // Index map: both-target aliases occupy 0..7, single-target 8..13,
    // translation-state registers 16..19.
    localparam int IX_BOTH_LAST = 7;
    localparam int IX_I_ALL     = 8;
    localparam int IX_I_VA_ASID = 9;
    localparam int IX_I_ASID    = 10;
    localparam int IX_D_ALL     = 11;
    localparam int IX_D_VA_ASID = 12;
    localparam int IX_D_ASID    = 13;
    localparam int IX_INV_FIRST = 16;
    localparam int IX_INV_LAST  = 19;

endpackage

// File: rtl/tlbm_index_decode.sv
module tlbm_index_decode
    import tlbm_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    output tlbm_dec_t        dec
);
    int unsigned ix;

    always_comb begin
        ix  = int'(idx);
        dec = '{to_i: 1'b0, to_d: 1'b0, inv: 1'b0, op: OP_ALL};
        if (ix <= IX_BOTH_LAST) begin
            dec.to_i = 1'b1;
            dec.to_d = 1'b1;
            // Pairs share one operation: unified and inner-shareable aliases
            case (ix >> 1)
                0:       dec.op = OP_ALL;
                1:       dec.op = OP_VA_ASID;
                2:       dec.op = OP_ASID;
                default: dec.op = OP_VA_ANY;
            endcase
        end else if (ix == IX_I_ALL) begin
            dec.to_i = 1'b1;
            dec.op   = OP_ALL;
        end else if (ix == IX_I_VA_ASID) begin
            dec.to_i = 1'b1;
            dec.op   = OP_VA_ASID;
        end else if (ix == IX_I_ASID) begin
            dec.to_i = 1'b1;
            dec.op   = OP_ASID;
        end else if (ix == IX_D_ALL) begin
            dec.to_d = 1'b1;
            dec.op   = OP_ALL;
        end else if (ix == IX_D_VA_ASID) begin
            dec.to_d = 1'b1;
            dec.op   = OP_VA_ASID;
        end else if (ix == IX_D_ASID) begin
            dec.to_d = 1'b1;
            dec.op   = OP_ASID;
        end else if (ix >= IX_INV_FIRST && ix <= IX_INV_LAST) begin
            dec.inv = 1'b1;
        end
    end
endmodule

// File: rtl/tlbm_field_extract.sv
module tlbm_field_extract
    import tlbm_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ASID_W     = 8
) (
    input  tlbm_op_e          op,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] va,
    output logic [ASID_W-1:0] asid
);
    localparam int PAGE_W = DATA_W - PAGE_SHIFT;

    logic uses_va;
    logic uses_asid;

    always_comb begin
        uses_va   = (op == OP_VA_ASID) || (op == OP_VA_ANY);
        uses_asid = (op == OP_VA_ASID) || (op == OP_ASID);
        va        = uses_va ? {data[DATA_W-1 -: PAGE_W], {PAGE_SHIFT{1'b0}}} : '0;
        asid      = uses_asid ? data[ASID_W-1:0] : '0;
    end
endmodule

// File: rtl/tlb_maint_decoder.sv
module tlb_maint_decoder
    import tlbm_pkg::*;
#(
    parameter int IDX_W      = 5,
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ASID_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              itlb_ready,
    output logic              itlb_cmd_valid,
    output logic [1:0]        itlb_cmd_op,
    output logic [DATA_W-1:0] itlb_cmd_va,
    output logic [ASID_W-1:0] itlb_cmd_asid,
    input  logic              dtlb_ready,
    output logic              dtlb_cmd_valid,
    output logic [1:0]        dtlb_cmd_op,
    output logic [DATA_W-1:0] dtlb_cmd_va,
    output logic [ASID_W-1:0] dtlb_cmd_asid,
    output logic              tlb_state_inv
);
    typedef struct packed {
        logic              valid;
        tlbm_op_e          op;
        logic [DATA_W-1:0] va;
        logic [ASID_W-1:0] asid;
    } cmd_t;

    typedef struct packed {
        cmd_t [NTGT-1:0] cmd;
        logic            inv;
    } state_t;

    tlbm_dec_t         dec;
    logic [DATA_W-1:0] ext_va;
    logic [ASID_W-1:0] ext_asid;
    logic [NTGT-1:0]   tgt_need;
    logic [NTGT-1:0]   tgt_rdy;
    logic              accept;
    state_t            state_d, state_q;

    tlbm_index_decode #(.IDX_W(IDX_W)) u_dec (
        .idx (wr_index),
        .dec (dec)
    );

    tlbm_field_extract #(
        .DATA_W     (DATA_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .ASID_W     (ASID_W)
    ) u_ext (
        .op   (dec.op),
        .data (wr_data),
        .va   (ext_va),
        .asid (ext_asid)
    );

    always_comb begin
        tgt_need = {dec.to_d, dec.to_i};
        tgt_rdy  = {dtlb_ready, itlb_ready};
        wr_ready = &(~tgt_need | tgt_rdy);
        accept   = wr_valid & wr_ready;

        state_d     = '0;
        state_d.inv = accept & dec.inv;
        for (int t = 0; t < NTGT; t++) begin
            if (accept && tgt_need[t]) begin
                state_d.cmd[t].valid = 1'b1;
                state_d.cmd[t].op    = dec.op;
                state_d.cmd[t].va    = ext_va;
                state_d.cmd[t].asid  = ext_asid;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign itlb_cmd_valid = state_q.cmd[0].valid;
    assign itlb_cmd_op    = state_q.cmd[0].op;
    assign itlb_cmd_va    = state_q.cmd[0].va;
    assign itlb_cmd_asid  = state_q.cmd[0].asid;
    assign dtlb_cmd_valid = state_q.cmd[1].valid;
    assign dtlb_cmd_op    = state_q.cmd[1].op;
    assign dtlb_cmd_va    = state_q.cmd[1].va;
    assign dtlb_cmd_asid  = state_q.cmd[1].asid;
    assign tlb_state_inv  = state_q.inv;
endmodule

// File: rtl/tlbm_checker.sv
module tlbm_checker #(
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ASID_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              itlb_cmd_valid,
    input logic [1:0]        itlb_cmd_op,
    input logic [DATA_W-1:0] itlb_cmd_va,
    input logic [ASID_W-1:0] itlb_cmd_asid,
    input logic              dtlb_cmd_valid,
    input logic [1:0]        dtlb_cmd_op,
    input logic [DATA_W-1:0] dtlb_cmd_va,
    input logic [ASID_W-1:0] dtlb_cmd_asid,
    input logic              tlb_state_inv
);
    // R11
    out_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (itlb_cmd_valid || dtlb_cmd_valid || tlb_state_inv) |-> $past(wr_valid && wr_ready));

    // R10
    stall_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> !(itlb_cmd_valid || dtlb_cmd_valid || tlb_state_inv));

    // R3
    page_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        itlb_cmd_valid |-> (itlb_cmd_va[PAGE_SHIFT-1:0] == '0));

    // R3
    page_aligned_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dtlb_cmd_valid |-> (dtlb_cmd_va[PAGE_SHIFT-1:0] == '0));

    // R4
    flush_all_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (itlb_cmd_valid && itlb_cmd_op == 2'd0) |-> (itlb_cmd_va == '0 && itlb_cmd_asid == '0));

    // R5
    va_any_no_asid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dtlb_cmd_valid && dtlb_cmd_op == 2'd3) |-> (dtlb_cmd_asid == '0));

    // R8
    inv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_state_inv |-> !(itlb_cmd_valid || dtlb_cmd_valid));

    // R2
    both_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (itlb_cmd_valid && dtlb_cmd_valid) |->
            (itlb_cmd_op == dtlb_cmd_op && itlb_cmd_va == dtlb_cmd_va
             && itlb_cmd_asid == dtlb_cmd_asid));
endmodule

bind tlb_maint_decoder tlbm_checker #(
    .DATA_W     (DATA_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .ASID_W     (ASID_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_valid       (wr_valid),
    .wr_ready       (wr_ready),
    .itlb_cmd_valid (itlb_cmd_valid),
    .itlb_cmd_op    (itlb_cmd_op),
    .itlb_cmd_va    (itlb_cmd_va),
    .itlb_cmd_asid  (itlb_cmd_asid),
    .dtlb_cmd_valid (dtlb_cmd_valid),
    .dtlb_cmd_op    (dtlb_cmd_op),
    .dtlb_cmd_va    (dtlb_cmd_va),
    .dtlb_cmd_asid  (dtlb_cmd_asid),
    .tlb_state_inv  (tlb_state_inv)
);

// File: tb/tlb_maint_decoder_tb.sv
module tlb_maint_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 5;
    localparam int DW    = 32;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_valid;
    logic [IDX_W-1:0] wr_index;
    logic [DW-1:0] wr_data;
    logic          wr_ready;
    logic          itlb_ready, dtlb_ready;
    logic          iv, dv, inv;
    logic [1:0]    iop, dop;
    logic [DW-1:0] iva, dva;
    logic [AW-1:0] ias, das;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_maint_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_index(wr_index),
        .wr_data(wr_data), .wr_ready(wr_ready),
        .itlb_ready(itlb_ready), .itlb_cmd_valid(iv), .itlb_cmd_op(iop),
        .itlb_cmd_va(iva), .itlb_cmd_asid(ias),
        .dtlb_ready(dtlb_ready), .dtlb_cmd_valid(dv), .dtlb_cmd_op(dop),
        .dtlb_cmd_va(dva), .dtlb_cmd_asid(das),
        .tlb_state_inv(inv)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected decode computed from the requirement text
    task automatic ref_model(input int ix, input logic [DW-1:0] d,
                             output logic ti, output logic td, output logic ei,
                             output logic [1:0] op, output string req);
        ti = 0; td = 0; ei = 0; op = 0; req = "R9";
        if (ix <= 7) begin
            ti = 1; td = 1; req = "R2";
            op = (ix/2 == 0) ? 2'd0 : (ix/2 == 1) ? 2'd2 : (ix/2 == 2) ? 2'd1 : 2'd3;
        end else if (ix >= 8 && ix <= 10) begin
            ti = 1; req = "R6";
            op = (ix == 8) ? 2'd0 : (ix == 9) ? 2'd2 : 2'd1;
        end else if (ix >= 11 && ix <= 13) begin
            td = 1; req = "R7";
            op = (ix == 11) ? 2'd0 : (ix == 12) ? 2'd2 : 2'd1;
        end else if (ix >= 16 && ix <= 19) begin
            ei = 1; req = "R8";
        end
        if (d == 0) ei = ei; // data does not affect routing
    endtask

    function automatic logic [DW-1:0] exp_va(input logic [1:0] op, input logic [DW-1:0] d);
        return (op == 2'd2 || op == 2'd3) ? {d[31:12], 12'h000} : '0;
    endfunction

    function automatic logic [AW-1:0] exp_asid(input logic [1:0] op, input logic [DW-1:0] d);
        return (op == 2'd1 || op == 2'd2) ? d[7:0] : '0;
    endfunction

    // Called at a negedge: drive, check ready, advance one cycle, check outputs
    task automatic do_write(input logic v, input int ix, input logic [DW-1:0] d,
                            input logic ir, input logic dr);
        logic ti, td, ei, rdy, acc;
        logic [1:0] op;
        string req;
        ref_model(ix, d, ti, td, ei, op, req);
        wr_valid = v; wr_index = IDX_W'(ix); wr_data = d;
        itlb_ready = ir; dtlb_ready = dr;
        rdy = !((ti && !ir) || (td && !dr));
        acc = v && rdy;
        #1;
        chk("R10", "wr_ready", 64'(wr_ready), 64'(rdy));
        @(negedge clk);
        chk(acc ? req : "R10", "itlb_valid", 64'(iv), 64'(acc && ti));
        chk(acc ? req : "R10", "dtlb_valid", 64'(dv), 64'(acc && td));
        chk(acc ? "R8" : "R10", "inv", 64'(inv), 64'(acc && ei));
        if (acc && ti) begin
            chk("R11", "itlb_op", 64'(iop), 64'(op));
            chk("R3", "itlb_va", 64'(iva), 64'(exp_va(op, d)));
            chk("R4", "itlb_asid", 64'(ias), 64'(exp_asid(op, d)));
        end
        if (acc && td) begin
            chk("R11", "dtlb_op", 64'(dop), 64'(op));
            chk("R3", "dtlb_va", 64'(dva), 64'(exp_va(op, d)));
            chk(op == 2'd3 ? "R5" : "R4", "dtlb_asid", 64'(das), 64'(exp_asid(op, d)));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 0; wr_valid = 0; wr_index = 0; wr_data = 0;
        itlb_ready = 1; dtlb_ready = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        wr_valid = 1; wr_index = 0;
        @(negedge clk);
        chk("R1", "valids in reset", 64'({iv, dv, inv}), 64'(0));
        wr_valid = 0;
        rst_n = 1;
        @(negedge clk);
        chk("R1", "valids after reset", 64'({iv, dv, inv}), 64'(0));

        // Directed sweep of every index, all ready
        for (int ix = 0; ix < 32; ix++) begin
            do_write(1, ix, 32'hABCD_E5A7, 1, 1);
            do_write(0, 0, 0, 1, 1); // R11: pulse drops
        end
        // R10: both-target op stalls on one side
        do_write(1, 2, 32'h1234_5678, 0, 1);
        do_write(1, 6, 32'h1234_5678, 1, 0);
        // R10: single-target unaffected by the other TLB
        do_write(1, 9, 32'hFFFF_F0FF, 1, 0);
        do_write(1, 12, 32'h0000_1001, 0, 1);
        // R8/R9: never stalled
        do_write(1, 17, 32'hFFFF_FFFF, 0, 0);
        do_write(1, 25, 32'hFFFF_FFFF, 0, 0);
        // R11: back-to-back accepts
        do_write(1, 4, 32'h0000_00FF, 1, 1);
        do_write(1, 3, 32'hFFFF_F000, 1, 1);

        for (int n = 0; n < 1500; n++)
            do_write(($urandom % 5) != 0, int'($urandom % 32), $urandom,
                     ($urandom % 4) != 0, ($urandom % 4) != 0);

        wr_valid = 0;
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule